// File: doc/BRIEF.md
# Cascadable Decimal Up/Down Counter Digit

This block holds one decimal digit (0 to 9) in a four-bit register and steps it by one on each rising clock edge, up or down as a direction input selects. An active-low enable input gates each step. A combinational active-low terminal flag tells the next digit when this digit is about to roll over. Several copies share one clock, and each copy's flag drives the next copy's enable, to form a multi-digit decimal counter.

Two level-sensitive controls act at once, with no clock edge needed. A high on `clear` zeroes the digit. A high on `load_en` copies `load_val` into the digit. `clear` wins when both are high. While either control is high, clock edges do not step the digit.

Top module: `bcd_updown_decade`

## Requirements
- R1: With `cin_n` low, `count_up` high, `clear` and `load_en` low and `q` below 9, a rising clock edge sets `q` to its old value plus one.
- R2: With `cin_n` low, `count_up` low, `clear` and `load_en` low and `q` between 1 and 9, a rising clock edge sets `q` to its old value minus one.
- R3: While `cin_n` is high, clock edges leave `q` unchanged.
- R4: A high on `clear` forces `q` to 0 without a clock edge and holds it there, whatever `load_en`, `cin_n` or `count_up` are.
- R5: With `clear` low, a rising `load_en` copies `load_val` into `q` without a clock edge, and no count step happens on an edge while `load_en` is high. Values 10 to 15 are loaded unchanged.
- R6: Counting up, an enabled edge takes `q` from 9, or from any value 10 to 15, to 0.
- R7: Counting down, an enabled edge takes `q` from 0, or from any value 10 to 15, to 9.
- R8: With `count_up` high, `cout_n` is low exactly when `q[0]`, `q[3]` and not `cin_n` are all true. It is high otherwise, and it follows its inputs with no clock.
- R9: With `count_up` low, `cout_n` is low exactly when `q` is 0 and `cin_n` is low. It is high otherwise.
- R10: Two digits on one clock, with the upper digit's `cin_n` driven from the lower digit's `cout_n`, count 00 through 99 and wrap to 00 going up, and count 00, 99, ..., 00 going down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge |
| clear | input | 1 | Active-high asynchronous clear of the digit |
| load_en | input | 1 | Active-high asynchronous parallel load |
| load_val | input | 4 | Value loaded while `load_en` is high |
| count_up | input | 1 | Direction: 1 up, 0 down |
| cin_n | input | 1 | Active-low count enable / carry from the previous digit |
| q | output | 4 | Current digit value |
| cout_n | output | 1 | Active-low terminal-count flag for the next digit |

## Verification
The bench builds the block with its default four-bit digit width and a terminal value of 9. This width is small enough to reach every state, including the six invalid codes 10 to 15, by a parallel load. Each invalid code can then be stepped in both directions. A second copy of the same block, chained through the carry pins, makes the full two-digit range of 00 to 99 reachable. This exposes the combinational ripple of the carry in both directions of wrap.

// File: rtl/bcd_pkg.sv
// Package: shared constants for the decimal counter digit.
// Assumes a binary-coded decimal digit; the width covers the largest code.
package bcd_pkg;
    parameter int DIGIT_W = 4;
    parameter int LAST_DIGIT = 9;
    localparam logic [DIGIT_W-1:0] LAST_CODE = DIGIT_W'(LAST_DIGIT);
    localparam logic [DIGIT_W-1:0] ZERO_CODE = '0;
endpackage

// File: rtl/bcd_step.sv
// Module: bcd_step
// Computes the value the digit takes after one count step in either
// direction. Assumes codes above LAST_CODE are invalid and steer them
// to the wrap value of the current direction.
module bcd_step
    import bcd_pkg::*;
#(
    parameter int W = DIGIT_W
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP  = W'(LAST_DIGIT);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] NONE = '0;

    // Purpose: pick the incremented, decremented or wrapped value.
    always_comb begin
        if (up) begin
            nxt = (cur >= TOP) ? NONE : cur + ONE;
        end else begin
            nxt = (cur == NONE || cur > TOP) ? TOP : cur - ONE;
        end
    end
endmodule

// File: rtl/bcd_term.sv
// Module: bcd_term
// Drives the active-low terminal-count flag that enables the next digit.
// Purely combinational, so a chain of digits ripples within one period.
// Assumes the up decode looks only at the two bits that are set in 9.
module bcd_term
    import bcd_pkg::*;
#(
    parameter int W = DIGIT_W
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    input  logic         cin_n,
    output logic         cout_n
);
    logic at_top;
    logic at_bottom;

    // Purpose: decode the terminal state of each direction.
    always_comb begin
        at_top    = cur[0] & cur[W-1];
        at_bottom = (cur == '0);
        cout_n    = ~((up ? at_top : at_bottom) & ~cin_n);
    end

    // Purpose: guard the flag against its required behaviour.
    always_comb begin
        if (cin_n) begin
            p_cout_idle_r8: assert (cout_n);
        end
        if (!cin_n && up && cur == W'(LAST_DIGIT)) begin
            p_cout_up_nine_r8: assert (!cout_n);
        end
        if (!cin_n && !up && cur == '0) begin
            p_cout_dn_zero_r9: assert (!cout_n);
        end
        if (!up && cur != '0) begin
            p_cout_dn_high_r9: assert (cout_n);
        end
    end
endmodule

// File: rtl/bcd_updown_decade.sv
// Module: bcd_updown_decade
// One decimal digit of an up/down counter with asynchronous clear and
// parallel load. Assumes clear and load_en are released well before the
// next rising clock edge, and load_val is steady while load_en is high.
module bcd_updown_decade
    import bcd_pkg::*;
(
    input  logic               clk,
    input  logic               clear,
    input  logic               load_en,
    input  logic [DIGIT_W-1:0] load_val,
    input  logic               count_up,
    input  logic               cin_n,
    output logic [DIGIT_W-1:0] q,
    output logic               cout_n
);
    logic [DIGIT_W-1:0] step_val;

    bcd_step #(.W(DIGIT_W)) u_step (
        .cur (q),
        .up  (count_up),
        .nxt (step_val)
    );

    bcd_term #(.W(DIGIT_W)) u_term (
        .cur    (q),
        .up     (count_up),
        .cin_n  (cin_n),
        .cout_n (cout_n)
    );

    // Purpose: digit register, clear over load over enabled count step.
    always_ff @(posedge clk or posedge clear or posedge load_en) begin
        if (clear) begin
            q <= ZERO_CODE;
        end else if (load_en) begin
            q <= load_val;
        end else if (!cin_n) begin
            q <= step_val;
        end
    end

    // Purpose: mark a clock period in which an asynchronous control fired.
    logic chk_async_seen;
    always_ff @(posedge clk or posedge clear or posedge load_en) begin
        if (clear || load_en) begin
            chk_async_seen <= 1'b1;
        end else begin
            chk_async_seen <= 1'b0;
        end
    end

    p_count_up_r1: assert property (@(posedge clk) disable iff (clear || load_en)
        (!cin_n && count_up && q < LAST_CODE) |=> (chk_async_seen || q == $past(q) + 4'd1));

    p_count_dn_r2: assert property (@(posedge clk) disable iff (clear || load_en)
        (!cin_n && !count_up && q != ZERO_CODE && q <= LAST_CODE)
        |=> (chk_async_seen || q == $past(q) - 4'd1));

    p_hold_r3: assert property (@(posedge clk) disable iff (clear || load_en)
        cin_n |=> (chk_async_seen || $stable(q)));

    p_clear_r4: assert property (@(posedge clk)
        (clear && $past(clear)) |-> q == ZERO_CODE);

    p_load_r5: assert property (@(posedge clk)
        (load_en && $past(load_en) && !clear && !$past(clear) && $stable(load_val))
        |-> q == load_val);

    p_wrap_up_r6: assert property (@(posedge clk) disable iff (clear || load_en)
        (!cin_n && count_up && q >= LAST_CODE) |=> (chk_async_seen || q == ZERO_CODE));

    p_wrap_dn_r7: assert property (@(posedge clk) disable iff (clear || load_en)
        (!cin_n && !count_up && (q == ZERO_CODE || q > LAST_CODE))
        |=> (chk_async_seen || q == LAST_CODE));
endmodule

// File: tb/bcd_updown_decade_tb.sv
`timescale 1ns/1ps
module bcd_updown_decade_tb;
    logic       clk = 1'b0;
    logic       clear = 1'b1;
    logic       load_en = 1'b0;
    logic [3:0] load_val = 4'd0;
    logic       count_up = 1'b1;
    logic       cin_n = 1'b1;
    logic [3:0] q;
    logic       cout_n;
    logic [3:0] q_hi;
    logic       cout_hi_n;
    logic       hi_load = 1'b0;
    logic [3:0] hi_val = 4'd0;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_updown_decade u_dut (
        .clk(clk), .clear(clear), .load_en(load_en), .load_val(load_val),
        .count_up(count_up), .cin_n(cin_n), .q(q), .cout_n(cout_n)
    );

    // Upper digit of the cascade, enabled by the lower digit's flag.
    bcd_updown_decade u_dut_hi (
        .clk(clk), .clear(clear), .load_en(hi_load), .load_val(hi_val),
        .count_up(count_up), .cin_n(cout_n), .q(q_hi), .cout_n(cout_hi_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Wait for a rising edge, then move 1 ns past it.
    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    function automatic bit exp_cout(input logic [3:0] v, input bit up, input bit ci_n);
        if (up) return !(v[0] && v[3] && !ci_n);
        return !(v == 4'd0 && !ci_n);
    endfunction

    task automatic do_load(input logic [3:0] v);
        load_val = v;
        load_en = 1'b1;
        #1;
        load_en = 1'b0;
    endtask

    task automatic t_reset();
        check(q == 4'd0, "R4 reset state", q, 0);
        check(q_hi == 4'd0, "R4 reset state hi", q_hi, 0);
    endtask

    task automatic t_count_up();
        int exp;
        clear = 1'b0;
        do_load(4'd2);
        count_up = 1'b1;
        cin_n = 1'b0;
        exp = 2;
        for (int i = 0; i < 6; i++) begin
            edge1();
            exp = exp + 1;
            check(q == 4'(exp), "R1 count up", q, exp);
        end
        edge1();
        check(q == 4'd9, "R1 count up to 9", q, 9);
        cin_n = 1'b1;
    endtask

    task automatic t_count_down();
        int exp;
        do_load(4'd9);
        count_up = 1'b0;
        cin_n = 1'b0;
        exp = 9;
        for (int i = 0; i < 9; i++) begin
            edge1();
            exp = exp - 1;
            check(q == 4'(exp), "R2 count down", q, exp);
        end
        cin_n = 1'b1;
    endtask

    task automatic t_hold();
        do_load(4'd5);
        cin_n = 1'b1;
        count_up = 1'b1;
        edge1();
        edge1();
        check(q == 4'd5, "R3 hold up", q, 5);
        count_up = 1'b0;
        edge1();
        check(q == 4'd5, "R3 hold down", q, 5);
    endtask

    task automatic t_clear();
        do_load(4'd7);
        cin_n = 1'b0;
        count_up = 1'b1;
        clear = 1'b1;
        #1;
        check(q == 4'd0, "R4 clear without edge", q, 0);
        load_val = 4'd6;
        load_en = 1'b1;
        edge1();
        check(q == 4'd0, "R4 clear beats load and count", q, 0);
        load_en = 1'b0;
        clear = 1'b0;
        cin_n = 1'b1;
        #1;
        check(q == 4'd0, "R4 stays clear after release", q, 0);
    endtask

    task automatic t_load();
        cin_n = 1'b0;
        count_up = 1'b1;
        load_val = 4'd3;
        load_en = 1'b1;
        #1;
        check(q == 4'd3, "R5 load without edge", q, 3);
        edge1();
        edge1();
        check(q == 4'd3, "R5 no count while loading", q, 3);
        load_en = 1'b0;
        edge1();
        check(q == 4'd4, "R5 count resumes after load", q, 4);
        cin_n = 1'b1;
        do_load(4'd13);
        check(q == 4'd13, "R5 invalid value loaded", q, 13);
    endtask

    task automatic t_wrap();
        count_up = 1'b1;
        do_load(4'd9);
        cin_n = 1'b0;
        edge1();
        check(q == 4'd0, "R6 wrap 9 to 0", q, 0);
        cin_n = 1'b1;
        for (int v = 10; v < 16; v++) begin
            do_load(4'(v));
            cin_n = 1'b0;
            edge1();
            cin_n = 1'b1;
            check(q == 4'd0, "R6 invalid up to 0", q, 0);
        end
        count_up = 1'b0;
        do_load(4'd0);
        cin_n = 1'b0;
        edge1();
        check(q == 4'd9, "R7 wrap 0 to 9", q, 9);
        cin_n = 1'b1;
        for (int v = 10; v < 16; v++) begin
            do_load(4'(v));
            cin_n = 1'b0;
            edge1();
            cin_n = 1'b1;
            check(q == 4'd9, "R7 invalid down to 9", q, 9);
        end
    endtask

    task automatic t_carry();
        for (int v = 0; v < 16; v++) begin
            do_load(4'(v));
            for (int d = 0; d < 2; d++) begin
                for (int c = 0; c < 2; c++) begin
                    count_up = d[0];
                    cin_n = c[0];
                    #0.1;
                    if (d == 1)
                        check(cout_n == exp_cout(4'(v), 1'b1, c[0]), "R8 carry up", cout_n,
                              exp_cout(4'(v), 1'b1, c[0]));
                    else
                        check(cout_n == exp_cout(4'(v), 1'b0, c[0]), "R9 carry down", cout_n,
                              exp_cout(4'(v), 1'b0, c[0]));
                end
            end
        end
        cin_n = 1'b1;
        #1;
    endtask

    task automatic t_cascade();
        int exp;
        int act;
        cin_n = 1'b1;
        clear = 1'b1;
        #1;
        clear = 1'b0;
        count_up = 1'b1;
        cin_n = 1'b0;
        exp = 0;
        for (int i = 0; i < 100; i++) begin
            if (exp == 99) begin
                #0.1;
                check(cout_hi_n == 1'b0, "R10 ripple flag at 99", cout_hi_n, 0);
            end
            edge1();
            exp = (exp + 1) % 100;
            act = q_hi * 10 + q;
            check(act == exp, "R10 cascade up", act, exp);
        end
        count_up = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (exp == 0) begin
                #0.1;
                check(cout_hi_n == 1'b0, "R10 ripple flag at 00", cout_hi_n, 0);
            end
            edge1();
            exp = (exp + 99) % 100;
            act = q_hi * 10 + q;
            check(act == exp, "R10 cascade down", act, exp);
        end
        cin_n = 1'b1;
    endtask

    initial begin
        edge1();
        edge1();
        t_reset();
        t_count_up();
        t_count_down();
        t_hold();
        t_clear();
        t_load();
        t_wrap();
        t_carry();
        t_cascade();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule